// File: doc/BRIEF.md
# Multi-Chain Scan Register

This block holds a group of state flip-flops for a piece of logic and makes each one testable by placing a 2:1 multiplexer in front of its D input. The flip-flops are split into several shift chains of independently chosen lengths. A single test-control input sets the mode for every chain at once. When it is high, every flip-flop loads its bit of the parallel next-state bus. When it is low, every chain shifts by one place per clock, taking a serial bit in at its head and presenting its tail bit for observation.

The serial ports are not dedicated pins. Each chain's scan input arrives on a pin that also carries a primary input, and each chain's scan output leaves on a pin that also carries a primary output. The same test-control signal drives the pin multiplexers, so one pin switches both the flip-flop mode and the pin function. While the chains shift, the primary-input value forwarded to the core logic is forced to zero. This keeps shift data from toggling the logic under test. All flip-flops run from one clock with no gating and share one synchronous active-high reset.

Top module: `multi_chain_scan_reg`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, every bit of `present_state` is 0 after that edge, whatever the value of `test_ctl`.
- R2: When `test_ctl` is 1 (capture mode) at a rising edge, `present_state` equals the `next_state` value sampled at that edge.
- R3: When `test_ctl` is 0 (shift mode), each chain moves one place toward its tail per edge and `next_state` has no effect. Chain c occupies `present_state` bits from its offset (the sum of the lengths of chains below c) up to offset+len-1. The lowest bit is the head and loads `shared_in[c]`; every other bit loads the bit one index below it.
- R4: In shift mode, `shared_out[c]` shows the tail bit of chain c (bit offset+len-1) in the same cycle, with no register in between.
- R5: In capture mode, `shared_out[c]` carries `core_out[c]` in the same cycle.
- R6: `core_in[c]` equals `shared_in[c]` in capture mode and is 0 in shift mode.
- R7: The chains have unequal lengths, with the default lengths 5, 3 and 4 for chains 0, 1 and 2. A bit entered at the head of chain c appears on `shared_out[c]` after exactly len(c) shift edges. A repeating 0,0,1,1 pattern shifted for the longest length plus 4 cycles reaches every tail in order.
- R8: `present_state` shows the flip-flop contents in both modes.
- R9: A load by shifting, then one capture edge, then shifting again puts the captured `next_state` bits out of each tail in order, tail bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every flip-flop |
| rst | input | 1 | Synchronous active-high reset, clears all flip-flops |
| test_ctl | input | 1 | 1 = capture next_state, 0 = shift chains |
| next_state | input | TOTAL | Parallel functional next-state bus |
| present_state | output | TOTAL | Flip-flop contents |
| shared_in | input | NUM_CHAINS | Primary-input pins that double as scan inputs |
| core_in | output | NUM_CHAINS | Primary-input values passed to core logic (0 while shifting) |
| core_out | input | NUM_CHAINS | Functional outputs from core logic |
| shared_out | output | NUM_CHAINS | Primary-output pins that double as scan outputs |

## Verification
Two kinds of result have different timing. The pin multiplexer results (`shared_out`, `core_in`) depend on the inputs and the current state in the same cycle. The driver therefore checks them 1 ns after it applies new inputs at the falling edge, before the next rising edge. The `present_state` result is due one rising edge after the inputs that cause it. The driver pushes that expected value into a queue, and a monitor pops it 1 ns after the following rising edge and compares it there. A flush of 0,0,1,1 and a load, capture and unload sequence drive the tail-timing checks cycle by cycle.

// File: rtl/scan_reg_pkg.sv
package scan_reg_pkg;
  // Width of one length field in the packed chain-length parameter.
  localparam int LEN_W = 8;

  typedef enum logic {
    MODE_SHIFT   = 1'b0,
    MODE_CAPTURE = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell
  import scan_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  scan_mode_e mode,
  input  logic       d,
  input  logic       sd,
  output logic       q
);
  logic pick;

  // Mux in front of a plain D flip-flop.
  always_comb pick = (mode == MODE_CAPTURE) ? d : sd;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= pick;
  end

  // R1: reset clears the cell regardless of mode
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == 1'b0));
endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import scan_reg_pkg::*;
#(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  scan_mode_e     mode,
  input  logic [LEN-1:0] d,
  input  logic           sin,
  output logic [LEN-1:0] q,
  output logic           sout
);
  // link[i] feeds the serial input of cell i
  logic [LEN:0] link;

  assign link[0] = sin;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    scan_cell u_cell (
      .clk (clk),
      .rst (rst),
      .mode(mode),
      .d   (d[i]),
      .sd  (link[i]),
      .q   (q[i])
    );
    assign link[i+1] = q[i];
  end

  assign sout = link[LEN];

  // R2: capture mode loads the parallel bus
  a_r2_capture_loads: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE) |=> (q == $past(d)));

  // R3: shift mode advances every cell by one place
  a_r3_shift_advances: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SHIFT) |=> (q == $past(link[LEN-1:0])));
endmodule

// File: rtl/scan_pin_share.sv
module scan_pin_share
  import scan_reg_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  scan_mode_e   mode,
  input  logic [N-1:0] shared_in,
  input  logic [N-1:0] tail,
  input  logic [N-1:0] core_out,
  output logic [N-1:0] core_in,
  output logic [N-1:0] shared_out
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      if (mode == MODE_CAPTURE) begin
        core_in[i]    = shared_in[i];
        shared_out[i] = core_out[i];
      end else begin
        core_in[i]    = 1'b0;
        shared_out[i] = tail[i];
      end
    end
  end

  // R6: core inputs stay quiet across consecutive shift cycles
  a_r6_core_in_quiet: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_SHIFT) && ($past(mode) == MODE_SHIFT)) |-> $stable(core_in));
endmodule

// File: rtl/multi_chain_scan_reg.sv
module multi_chain_scan_reg
  import scan_reg_pkg::*;
#(
  parameter int                          NUM_CHAINS = 3,
  // Field c (bits c*8 +: 8) holds the length of chain c.
  parameter logic [NUM_CHAINS*LEN_W-1:0] CHAIN_LENS = {8'd4, 8'd3, 8'd5},
  localparam int                         TOTAL      = sum_below(NUM_CHAINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  test_ctl,
  input  logic [TOTAL-1:0]      next_state,
  output logic [TOTAL-1:0]      present_state,
  input  logic [NUM_CHAINS-1:0] shared_in,
  output logic [NUM_CHAINS-1:0] core_in,
  input  logic [NUM_CHAINS-1:0] core_out,
  output logic [NUM_CHAINS-1:0] shared_out
);
  function automatic int len_of(input int c);
    return int'(CHAIN_LENS[c*LEN_W +: LEN_W]);
  endfunction

  function automatic int sum_below(input int c);
    int acc = 0;
    for (int k = 0; k < c; k++) acc += len_of(k);
    return acc;
  endfunction

  scan_mode_e            mode;
  logic [NUM_CHAINS-1:0] tails;

  assign mode = scan_mode_e'(test_ctl);

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int L = len_of(c);
    localparam int O = sum_below(c);

    scan_chain #(.LEN(L)) u_chain (
      .clk (clk),
      .rst (rst),
      .mode(mode),
      .d   (next_state[O +: L]),
      .sin (shared_in[c]),
      .q   (present_state[O +: L]),
      .sout(tails[c])
    );

    // R4 / R7: the bit next to the tail reaches the output pin one shift later
    if (L > 1) begin : g_long
      a_r4_tail_on_pin: assert property (@(posedge clk) disable iff (rst)
        !test_ctl |=> (test_ctl || (shared_out[c] == $past(present_state[O+L-2]))));
    end else begin : g_short
      a_r4_tail_on_pin: assert property (@(posedge clk) disable iff (rst)
        !test_ctl |=> (test_ctl || (shared_out[c] == $past(shared_in[c]))));
    end
  end

  scan_pin_share #(.N(NUM_CHAINS)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .shared_in (shared_in),
    .tail      (tails),
    .core_out  (core_out),
    .core_in   (core_in),
    .shared_out(shared_out)
  );
endmodule

// File: tb/multi_chain_scan_reg_bench.sv
`timescale 1ns/100ps
module multi_chain_scan_reg_bench;
  localparam int          NC   = 3;
  localparam logic [23:0] LENS = {8'd4, 8'd3, 8'd5};
  localparam int          TOT  = 12;
  localparam int          LEN [NC] = '{5, 3, 4};
  localparam int          OFF [NC] = '{0, 5, 8};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tc  = 1'b0;
  logic [TOT-1:0] nxt = '0;
  logic [TOT-1:0] ps;
  logic [NC-1:0]  sh_in = '0, core_out = '0, core_in, sh_out;

  always #2.5 clk = ~clk;

  multi_chain_scan_reg #(.NUM_CHAINS(NC), .CHAIN_LENS(LENS)) u_multi_chain_scan_reg (
    .clk(clk), .rst(rst), .test_ctl(tc), .next_state(nxt), .present_state(ps),
    .shared_in(sh_in), .core_in(core_in), .core_out(core_out), .shared_out(sh_out)
  );

  int n_run = 0, n_fail = 0;
  logic [TOT-1:0] model = '0;
  bit known = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [TOT-1:0] st; string tag; } exp_t;
  exp_t sbq[$];

  function automatic void check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endfunction

  // Driver: apply inputs, check same-cycle pin results, queue the state due next edge.
  task automatic step(input logic r, input logic t, input logic [TOT-1:0] n,
                      input logic [NC-1:0] si, input logic [NC-1:0] co, input string tag);
    logic [NC-1:0] exp_so, exp_ci;
    @(negedge clk);
    rst = r; tc = t; nxt = n; sh_in = si; core_out = co;
    #1;
    if (known) begin
      for (int c = 0; c < NC; c++) begin
        exp_so[c] = t ? co[c] : model[OFF[c]+LEN[c]-1];
        exp_ci[c] = t ? si[c] : 1'b0;
      end
      check(t ? "R5 shared_out" : "R4 shared_out", 16'(sh_out), 16'(exp_so));
      check("R6 core_in", 16'(core_in), 16'(exp_ci));
    end
    if (r) model = '0;
    else if (t) model = n;
    else begin
      for (int c = 0; c < NC; c++) begin
        for (int k = LEN[c]-1; k > 0; k--) model[OFF[c]+k] = model[OFF[c]+k-1];
        model[OFF[c]] = si[c];
      end
    end
    if (r) known = 1'b1;
    sbq.push_back('{model, tag});
  endtask

  // Monitor: compare present_state one edge after each driven cycle.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(e.tag, 16'(ps), 16'(e.st));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset in shift mode with all inputs high
    step(1, 0, '1, '1, '1, "R1 reset shift mode");
    step(1, 0, '1, '1, '1, "R1 reset held");
    // R2 / R8: capture distinct patterns
    step(0, 1, 12'hA5C, 3'b101, 3'b010, "R2 capture A5C");
    step(0, 1, 12'h3F0, 3'b010, 3'b101, "R2 capture 3F0");
    step(0, 1, 12'h00F, 3'b111, 3'b000, "R8 capture 00F");
    // R3: shifting ignores next_state noise
    for (int i = 0; i < 8; i++)
      step(0, 0, ~12'(i * 37), 3'((i * 5) % 8), 3'(i), "R3 shift");
    // R7: 0011 flush over longest length + 4 cycles
    step(1, 0, '0, '0, '0, "R1 reset before flush");
    for (int i = 0; i < 9; i++)
      step(0, 0, 12'hFFF, {3{1'(i >> 1)}}, '0, "R7 flush");
    // R9: load by shift, capture once, unload
    for (int i = 0; i < 5; i++)
      step(0, 0, '0, 3'(i + 3), '0, "R9 load");
    step(0, 1, 12'hC3A, 3'b000, 3'b110, "R9 capture C3A");
    for (int i = 0; i < 6; i++)
      step(0, 0, 12'h555, 3'b000, '0, "R9 unload");
    // R1: reset while in capture mode
    step(1, 1, '1, '1, '1, "R1 reset capture mode");
    step(0, 1, 12'h0A0, 3'b001, 3'b011, "R8 capture after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule